// File: doc/BRIEF.md
# Multi-Domain Clock Selector and Divider

This block produces the clocks of a small microcontroller from three free-running inputs: an external clock, a fast internal oscillator (nominally 24 MHz) and a slow low-power oscillator (nominally 32 kHz). It has five outputs: a processor clock, a 12 MHz bus clock for the USB engine, an interval-timer clock, a capture-timer clock, and a test clock that drives a pin. Each output has its own source selector. The processor, USB and interval-timer paths also have a divider. The test clock can carry the processor clock after its divider, and the capture-timer clock can be chained in as the interval-timer source.

Software sets the selectors and ratios through a small write-only register port clocked by `cfgClk`. Each selector switches without glitches. It stops the old clock while that clock is low, waits two falling edges of the new clock, and then lets the new clock through. Each divider passes one full source high phase out of every N source cycles. A new ratio is loaded only when the current output period ends. The external input noise filter is not modelled, so the test clock uses the external clock directly.

Top module: `clkGen`

## Requirements
- R1: After reset, every register field is 0 except the USB halve bit, which is 1. The processor, interval-timer, capture and test clocks therefore run at the fast-oscillator period, and the USB clock runs at twice that period.
- R2: Register 0 bit 0 selects the processor clock source: 0 is the fast oscillator, 1 is the external clock.
- R3: Register 0 bits 3:1 hold a divider code c. The processor period is 2^c source periods for c = 0 to 5, and 128 source periods for c = 6 and c = 7.
- R4: Register 1 bit 0 selects the USB source (0 fast, 1 external). Register 1 bit 1 set to 1 halves the frequency, so the period is 2 source periods; set to 0, the period is 1 source period.
- R5: Register 3 bits 1:0 select the capture clock: 0 fast, 1 external, 2 slow. Code 3 also selects the slow oscillator.
- R6: Register 2 bits 1:0 select the interval-timer source: 0 fast, 1 external, 2 slow, 3 the capture clock.
- R7: Register 2 bits 3:2 hold a prescale code p. The interval-timer period is exactly p+1 periods of its selected source, and this includes divide-by-3.
- R8: Register 3 bits 3:2 select the test clock: 0 fast, 1 external, 2 slow, 3 the processor clock after its divider.
- R9: No output ever has a high pulse shorter than the shortest source half-period, including while selectors and ratios change at random.
- R10: A new divider ratio takes effect only at the end of the current output period. After the processor ratio changes from 128 to 1, the next rising edge comes a full 128 source periods after the previous one.
- R11: A write stores its data only in the register that `wrAddr` names (0 to 3). The other fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset |
| cfgClk | input | 1 | Clock of the register write port |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | Register index |
| wrData | input | 4 | Write data |
| extClk | input | 1 | External clock |
| oscFast | input | 1 | Fast internal oscillator |
| oscSlow | input | 1 | Slow low-power oscillator |
| cpuClk | output | 1 | Processor clock |
| usbClk | output | 1 | USB clock |
| itClk | output | 1 | Interval-timer clock |
| capClk | output | 1 | Capture-timer clock |
| clkOut | output | 1 | Test clock for the pin |

## Verification
Faults in this block appear at the ports within a few output periods. A stuck or wrong register field shows up as a period other than the expected multiple of a source period. A wrong synchronizer state in a selector shows up as a missing clock or as two sources ORed together, which gives a high pulse shorter than the source half-period or an irregular period. A divider counter that reloads at the wrong moment gives either a wrong steady period or a shortened first period after a ratio change. The bench measures the time between rising edges against a computed expectation. It also records the width of every high pulse on all five outputs throughout the run.

// File: rtl/clkGenPkg.sv
`timescale 1ns/1ps
package clkGenPkg;
  parameter int ADDR_W      = 2;
  parameter int DATA_W      = 4;
  parameter int CPU_MAX_EXP = 7;
  parameter int CPU_CNT_W   = CPU_MAX_EXP;
  parameter int IT_PRE_W    = 2;

  // control-to-datapath configuration bundle
  typedef struct packed {
    logic                cpuSrc;
    logic [2:0]          cpuDiv;
    logic                usbSrc;
    logic                usbHalve;
    logic [1:0]          itSrc;
    logic [IT_PRE_W-1:0] itPre;
    logic [1:0]          capSrc;
    logic [1:0]          outSel;
  } clkCfgT;

  parameter clkCfgT CFG_RESET = '{cpuSrc: 1'b0, cpuDiv: 3'd0, usbSrc: 1'b0,
                                  usbHalve: 1'b1, itSrc: 2'd0, itPre: '0,
                                  capSrc: 2'd0, outSel: 2'd0};
endpackage

// File: rtl/clkGlitchMux.sv
`timescale 1ns/1ps
module clkGlitchMux #(
  parameter int N = 2,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          rstN,
  input  logic [N-1:0]  clkIn,
  input  logic [SW-1:0] sel,
  output logic          clkOut
);
  logic [N-1:0] en;
  logic [N-1:0] want;

  // a source may start only when every other source is fully stopped
  always_comb begin
    for (int i = 0; i < N; i++) begin
      want[i] = (sel == SW'(i)) && ((en & ~(N'(1) << i)) == '0);
    end
  end

  for (genvar g = 0; g < N; g++) begin : gSrc
    logic stageQ;
    logic enQ;
    always_ff @(negedge clkIn[g] or negedge rstN) begin
      if (!rstN) begin
        stageQ <= 1'b0;
        enQ    <= 1'b0;
      end else begin
        stageQ <= want[g];
        enQ    <= stageQ;
      end
    end
    assign en[g] = enQ;
  end

  assign clkOut = |(clkIn & en);
endmodule

// File: rtl/clkPulseDiv.sv
`timescale 1ns/1ps
module clkPulseDiv #(
  parameter int W = 2
) (
  input  logic         rstN,
  input  logic         clkIn,
  input  logic [W-1:0] ratioM1,
  output logic         clkOut
);
  logic [W-1:0] cnt;
  logic         gateEn;

  // ratio is sampled only when a period closes
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (cnt == '0)   cnt <= ratioM1;
    else                  cnt <= cnt - 1'b1;
  end

  // gate updated while the clock is low
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) gateEn <= 1'b0;
    else       gateEn <= (cnt == '0);
  end

  assign clkOut = clkIn & gateEn;
endmodule

// File: rtl/clkCtrl.sv
`timescale 1ns/1ps
module clkCtrl
  import clkGenPkg::*;
(
  input  logic              cfgClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output clkCfgT            cfg
);
  always_ff @(posedge cfgClk or negedge rstN) begin
    if (!rstN) begin
      cfg <= CFG_RESET;
    end else if (wrEn) begin
      case (wrAddr)
        2'd0: begin cfg.cpuSrc <= wrData[0]; cfg.cpuDiv   <= wrData[3:1]; end
        2'd1: begin cfg.usbSrc <= wrData[0]; cfg.usbHalve <= wrData[1];   end
        2'd2: begin cfg.itSrc  <= wrData[1:0]; cfg.itPre  <= wrData[3:2]; end
        default: begin cfg.capSrc <= wrData[1:0]; cfg.outSel <= wrData[3:2]; end
      endcase
    end
  end
endmodule

// File: rtl/clkPath.sv
`timescale 1ns/1ps
module clkPath
  import clkGenPkg::*;
(
  input  logic   rstN,
  input  clkCfgT cfg,
  input  logic   extClk,
  input  logic   oscFast,
  input  logic   oscSlow,
  output logic   cpuClk,
  output logic   usbClk,
  output logic   itClk,
  output logic   capClk,
  output logic   clkOut
);
  logic                 cpuRaw, usbRaw, itRaw;
  logic [2:0]           cpuExp;
  logic [CPU_CNT_W-1:0] cpuRatio;
  logic [1:0]           capSel;

  always_comb begin
    cpuExp   = (cfg.cpuDiv >= 3'd6) ? 3'(CPU_MAX_EXP) : cfg.cpuDiv;
    cpuRatio = CPU_CNT_W'((32'd1 << cpuExp) - 32'd1);
    capSel   = (cfg.capSrc == 2'd3) ? 2'd2 : cfg.capSrc;
  end

  clkGlitchMux #(.N(2)) i_cpuMux (.rstN(rstN), .clkIn({extClk, oscFast}),
                                  .sel(cfg.cpuSrc), .clkOut(cpuRaw));
  clkPulseDiv #(.W(CPU_CNT_W)) i_cpuDiv (.rstN(rstN), .clkIn(cpuRaw),
                                         .ratioM1(cpuRatio), .clkOut(cpuClk));

  clkGlitchMux #(.N(2)) i_usbMux (.rstN(rstN), .clkIn({extClk, oscFast}),
                                  .sel(cfg.usbSrc), .clkOut(usbRaw));
  clkPulseDiv #(.W(1)) i_usbDiv (.rstN(rstN), .clkIn(usbRaw),
                                 .ratioM1(cfg.usbHalve), .clkOut(usbClk));

  clkGlitchMux #(.N(3)) i_capMux (.rstN(rstN), .clkIn({oscSlow, extClk, oscFast}),
                                  .sel(capSel), .clkOut(capClk));

  clkGlitchMux #(.N(4)) i_itMux (.rstN(rstN), .clkIn({capClk, oscSlow, extClk, oscFast}),
                                 .sel(cfg.itSrc), .clkOut(itRaw));
  clkPulseDiv #(.W(IT_PRE_W)) i_itDiv (.rstN(rstN), .clkIn(itRaw),
                                       .ratioM1(cfg.itPre), .clkOut(itClk));

  // external filter modelled as pass-through
  clkGlitchMux #(.N(4)) i_outMux (.rstN(rstN), .clkIn({cpuClk, oscSlow, extClk, oscFast}),
                                  .sel(cfg.outSel), .clkOut(clkOut));
endmodule

// File: rtl/clkGen.sv
`timescale 1ns/1ps
module clkGen
  import clkGenPkg::*;
(
  input  logic              rstN,
  input  logic              cfgClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              extClk,
  input  logic              oscFast,
  input  logic              oscSlow,
  output logic              cpuClk,
  output logic              usbClk,
  output logic              itClk,
  output logic              capClk,
  output logic              clkOut
);
  clkCfgT cfg;

  clkCtrl i_ctrl (.cfgClk(cfgClk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
                  .wrData(wrData), .cfg(cfg));

  clkPath i_path (.rstN(rstN), .cfg(cfg), .extClk(extClk), .oscFast(oscFast),
                  .oscSlow(oscSlow), .cpuClk(cpuClk), .usbClk(usbClk),
                  .itClk(itClk), .capClk(capClk), .clkOut(clkOut));
endmodule

// File: rtl/clkGenChecker.sv
`timescale 1ns/1ps
module clkGenChecker
  import clkGenPkg::*;
(
  input logic              cfgClk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input clkCfgT            cfg
);
  logic started;
  always_ff @(posedge cfgClk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  a_r1_reset_defaults: assert property (@(posedge cfgClk) disable iff (!rstN)
    !started |-> cfg == CFG_RESET);

  a_r3_cpu_write: assert property (@(posedge cfgClk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd0) |=> (cfg.cpuDiv == $past(wrData[3:1]) && cfg.cpuSrc == $past(wrData[0])));

  a_r4_usb_write: assert property (@(posedge cfgClk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd1) |=> (cfg.usbHalve == $past(wrData[1]) && cfg.usbSrc == $past(wrData[0])));

  a_r8_out_write: assert property (@(posedge cfgClk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3) |=> (cfg.outSel == $past(wrData[3:2]) && cfg.capSrc == $past(wrData[1:0])));

  a_r11_hold_idle: assert property (@(posedge cfgClk) disable iff (!rstN)
    !wrEn |=> $stable(cfg));

  a_r11_other_regs: assert property (@(posedge cfgClk) disable iff (!rstN)
    (wrEn && wrAddr != 2'd2) |=> (cfg.itSrc == $past(cfg.itSrc) && cfg.itPre == $past(cfg.itPre)));
endmodule

bind clkGen clkGenChecker i_clkGenChecker (
  .cfgClk(cfgClk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .cfg(cfg)
);

// File: tb/test_clkGen.sv
`timescale 1ns/1ps
module test_clkGen;
  logic rstN = 1'b0, cfgClk = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [3:0] wrData = '0;
  logic extClk = 1'b0, oscFast = 1'b0, oscSlow = 1'b0;
  logic cpuClk, usbClk, itClk, capClk, clkOut;

  int errors = 0, checks = 0, glitches = 0;
  bit done = 1'b0;

  localparam real P_FAST = 10.0, P_EXT = 14.0, P_SLOW = 60.0, SETTLE = 5000.0;

  always #4  cfgClk  = ~cfgClk;
  always #5  oscFast = ~oscFast;
  always #7  extClk  = ~extClk;
  always #30 oscSlow = ~oscSlow;

  clkGen i_clkGen (.rstN(rstN), .cfgClk(cfgClk), .wrEn(wrEn), .wrAddr(wrAddr),
                   .wrData(wrData), .extClk(extClk), .oscFast(oscFast),
                   .oscSlow(oscSlow), .cpuClk(cpuClk), .usbClk(usbClk),
                   .itClk(itClk), .capClk(capClk), .clkOut(clkOut));

  // R9 pulse-width monitor on every output
  wire [4:0] outs = {clkOut, capClk, itClk, usbClk, cpuClk};
  for (genvar g = 0; g < 5; g++) begin : gMon
    realtime tRise;
    always @(posedge outs[g]) tRise = $realtime;
    always @(negedge outs[g]) if (rstN && ($realtime - tRise) < 4.9) glitches++;
  end

  // shadow configuration
  int cpuSrc = 0, cpuDiv = 0, usbSrc = 0, usbHalve = 1, itSrc = 0, itPre = 0, capSrc = 0, outSel = 0;

  function automatic real srcPer(int s);
    return (s == 0) ? P_FAST : (s == 1) ? P_EXT : P_SLOW;
  endfunction
  function automatic real cpuPer();
    int e = (cpuDiv >= 6) ? 7 : cpuDiv;
    return srcPer(cpuSrc) * real'(1 << e);
  endfunction
  function automatic real capPer();
    return srcPer((capSrc == 3) ? 2 : capSrc);
  endfunction
  function automatic real itPer();
    return ((itSrc == 3) ? capPer() : srcPer(itSrc)) * real'(itPre + 1);
  endfunction
  function automatic real outPer();
    return (outSel == 3) ? cpuPer() : srcPer(outSel);
  endfunction

  task automatic check(input string req, input real got, input real exp);
    checks++;
    if (got < exp - 0.01 || got > exp + 0.01) begin
      errors++;
      $display("FAIL %s: actual %0.2f expected %0.2f", req, got, exp);
    end
  endtask

  task automatic writeReg(input int a, input int d);
    @(negedge cfgClk);
    wrEn = 1'b1; wrAddr = 2'(a); wrData = 4'(d);
    @(negedge cfgClk);
    wrEn = 1'b0;
    case (a)
      0: begin cpuSrc = d & 1; cpuDiv = (d >> 1) & 7; end
      1: begin usbSrc = d & 1; usbHalve = (d >> 1) & 1; end
      2: begin itSrc = d & 3; itPre = (d >> 2) & 3; end
      default: begin capSrc = d & 3; outSel = (d >> 2) & 3; end
    endcase
  endtask

  task automatic waitRise(input int w);
    case (w)
      0: @(posedge cpuClk);
      1: @(posedge usbClk);
      2: @(posedge itClk);
      3: @(posedge capClk);
      default: @(posedge clkOut);
    endcase
  endtask

  task automatic measure(input int w, output real p);
    realtime t1;
    #(SETTLE);
    waitRise(w); t1 = $realtime;
    waitRise(w); p = $realtime - t1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(1_400_000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    real p;
    realtime t0;
    void'($urandom(32'd2024));
    #33 rstN = 1'b1;

    // R1 reset state
    measure(0, p); check("R1 cpu", p, P_FAST);
    measure(1, p); check("R1 usb", p, 2.0 * P_FAST);
    measure(2, p); check("R1 itimer", p, P_FAST);
    measure(3, p); check("R1 capture", p, P_FAST);
    measure(4, p); check("R1 clkout", p, P_FAST);

    // R2/R3 every divider code on both sources
    for (int c = 0; c < 8; c++) begin
      writeReg(0, (c << 1) | (c & 1));
      measure(0, p); check("R3 cpu code", p, cpuPer());
    end
    writeReg(0, 1 << 1); measure(0, p); check("R2 cpu fast", p, cpuPer());
    writeReg(0, (1 << 1) | 1); measure(0, p); check("R2 cpu ext", p, cpuPer());

    // R4 usb
    writeReg(1, 1); measure(1, p); check("R4 usb ext /1", p, P_EXT);
    writeReg(1, 3); measure(1, p); check("R4 usb ext /2", p, 2.0 * P_EXT);
    writeReg(1, 2); measure(1, p); check("R4 usb fast /2", p, 2.0 * P_FAST);

    // R5 capture sources
    for (int s = 0; s < 4; s++) begin
      writeReg(3, s); measure(3, p); check("R5 capture", p, capPer());
    end

    // R6/R7 interval timer incl. chaining and divide-by-3
    writeReg(3, 1);
    for (int s = 0; s < 4; s++) begin
      writeReg(2, (2 << 2) | s); measure(2, p); check("R6 itimer src /3", p, itPer());
    end
    for (int q = 0; q < 4; q++) begin
      writeReg(2, (q << 2) | 1); measure(2, p); check("R7 itimer prescale", p, itPer());
    end

    // R8 clock-out sources; processor at fast /4
    writeReg(0, 2 << 1);
    for (int s = 0; s < 4; s++) begin
      writeReg(3, s << 2); measure(4, p); check("R8 clkout", p, outPer());
    end

    // R10 ratio applies at the period boundary
    writeReg(3, 0);
    writeReg(0, 7 << 1);
    #(SETTLE);
    @(posedge cpuClk); t0 = $realtime;
    #20;
    writeReg(0, 0);
    @(posedge cpuClk);
    check("R10 first period after change", $realtime - t0, 128.0 * P_FAST);
    measure(0, p); check("R10 new ratio", p, P_FAST);

    // R11 write to one register leaves the others alone
    writeReg(2, (1 << 2) | 1);
    writeReg(1, 0);
    writeReg(0, 1 << 1);
    measure(2, p); check("R11 itimer kept", p, 2.0 * P_EXT);

    // random configurations
    for (int k = 0; k < 12; k++) begin
      int d0 = $urandom_range(0, 15);
      int d2 = $urandom_range(0, 15);
      int d3 = $urandom_range(0, 3);
      writeReg(0, d0); writeReg(2, d2); writeReg(3, d3);
      measure(0, p); check("R3 random cpu", p, cpuPer());
      measure(2, p); check("R7 random itimer", p, itPer());
    end

    // R9 switching stress
    for (int k = 0; k < 60; k++) begin
      writeReg($urandom_range(0, 3), $urandom_range(0, 15));
      #($urandom_range(10, 300));
    end
    #(SETTLE);
    checks++;
    if (glitches != 0) begin
      errors++;
      $display("FAIL R9 short pulses: actual %0d expected 0", glitches);
    end

    done = 1'b1;
    summary();
  end
endmodule